// File: doc/BRIEF.md
# Compare-Match Event Generator

This block holds a small bank of 32-bit match registers that watch a free-running 32-bit count supplied from outside. Software schedules a single future event by reading the count, adding a delay with plain modular 32-bit addition, and writing the sum into one of the match registers. That write arms the slot. When the count next equals the stored value, the slot latches a sticky flag and disarms itself. The count itself never stops or reloads, so it can serve as a time base while it also schedules events.

The interrupt output is the OR of all sticky flags. Software clears flags by writing ones to a flag register. The match registers sit at consecutive word offsets starting at 0x60 (slot i at 0x60 + 4*i). The flag register sits at 0x80. Reads pass through a one-cycle registered path: a read request returns its data together with a valid pulse on the next cycle. The read path has no back-pressure, and the requester must accept each response in the cycle it arrives.

Top module: `cmp_event_gen`

## Requirements
- R1: After reset, every match value reads 0, every flag is 0 and `irq_o` is low. No slot is armed, so a count equal to a reset value raises nothing.
- R2: A write to offset 0x60 + 4*i (i from 0 to 7) stores the full 32-bit data in slot i and arms it. A read of that offset returns the stored value one cycle after the read request, with `bus_rvalid` high.
- R3: If slot i is armed and, at a clock edge, `count_in` equals its value, flag bit i is set at that edge. Several slots matching in the same cycle all set their flags.
- R4: A slot that has fired is disarmed. Its flag is not set again when the count returns to the same value, until the slot is written again.
- R5: A write to offset 0x80 clears flag bit i for every data bit i that is 1. Data bits that are 0 leave their flags unchanged.
- R6: `irq_o` is high exactly when at least one flag bit is set. A read of 0x80 returns the flags in bits 7:0, with bit i for slot i and zeros above.
- R7: If the count equals a slot's value in the same cycle in which that slot is written, no event fires in that cycle. The slot fires on the next equality after the write.
- R8: Matching is pure 32-bit equality on a count that wraps from 0xFFFFFFFF to 0. A target computed as count plus delay modulo 2^32 fires after the wrap and not before it.
- R9: When a slot matches in the same cycle that a write to 0x80 clears its flag, the flag ends up set.
- R10: A write to any offset other than the slot offsets and 0x80, including an offset that is not word aligned, changes no slot value, no arming and no flag. A read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 8 | Byte offset for a read or a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Pulses one cycle after each read request |
| count_in | input | 32 | Free-running count being watched |
| irq_o | output | 1 | Event interrupt, the OR of all flags |

## Verification
The assertions inside the slot logic check four things on every cycle. A match on an armed slot sets its flag and disarms the slot on the next edge. A write in the same cycle as a match suppresses that match. A clear removes a flag only when no match competes with it, and a match wins when one does. The address decoder is checked to select at most one slot. Some behaviour only the bench scenarios can show, because it needs values read back or a history of several events: the counting through the wrap, a slot staying silent after it has fired, the masking done by the clear data, the unmapped offsets having no effect, and the read-back contents.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  // default register layout of the block
  localparam int unsigned SLOT_COUNT_DEF = 8;
  localparam int unsigned ADDR_W_DEF     = 8;
  localparam int unsigned DATA_W_DEF     = 32;
  localparam logic [7:0]  SLOT_BASE_DEF  = 8'h60;
  localparam logic [7:0]  FLAG_OFF_DEF   = 8'h80;
endpackage

// File: rtl/cmp_addr_dec.sv
module cmp_addr_dec #(
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned AW     = 8,
  parameter logic [AW-1:0] BASE = 8'h60,
  parameter logic [AW-1:0] FLAG = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  output logic [N_SLOT-1:0] slot_sel,
  output logic              flag_sel
);
  localparam int unsigned SPAN = 4 * N_SLOT;

  logic [AW:0] rel;
  logic        in_win;

  always_comb begin
    rel    = {1'b0, addr} - {1'b0, BASE};
    in_win = (addr >= BASE) && (rel < (AW+1)'(SPAN)) && (rel[1:0] == 2'b00);
    flag_sel = (addr == FLAG);
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_sel
    assign slot_sel[i] = in_win && (rel[AW:2] == (AW-1)'(i));
  end

  // R10
  slot_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));
endmodule

// File: rtl/cmp_slot.sv
module cmp_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          clr,
  input  logic [DW-1:0] count,
  output logic [DW-1:0] value,
  output logic          flag
);
  logic armed;
  logic hit;

  // a write in the same cycle overrides the match
  assign hit = armed && !load && (count == value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      armed <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (load) begin
        value <= load_val;
        armed <= 1'b1;
      end else if (hit) begin
        armed <= 1'b0;
      end
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R3
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R4
  hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !armed);
  // R7
  load_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flag) |=> !flag);
  // R5
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> flag);
endmodule

// File: rtl/cmp_rd_path.sv
module cmp_rd_path #(
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [N_SLOT-1:0] slot_sel,
  input  logic              flag_sel,
  input  logic [DW-1:0]     values [N_SLOT],
  input  logic [N_SLOT-1:0] flags,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (slot_sel[i]) nxt = nxt | values[i];
    end
    if (flag_sel) nxt = DW'(flags);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= nxt;
    end
  end

  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen
  import cmp_evt_pkg::*;
#(
  parameter int unsigned N_SLOT = SLOT_COUNT_DEF,
  parameter int unsigned AW     = ADDR_W_DEF,
  parameter int unsigned DW     = DATA_W_DEF,
  parameter logic [AW-1:0] BASE = AW'(SLOT_BASE_DEF),
  parameter logic [AW-1:0] FLAG = AW'(FLAG_OFF_DEF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic [DW-1:0] count_in,
  output logic          irq_o
);
  logic [N_SLOT-1:0] slot_sel;
  logic              flag_sel;
  logic [N_SLOT-1:0] flags;
  logic [DW-1:0]     values [N_SLOT];

  cmp_addr_dec #(.N_SLOT(N_SLOT), .AW(AW), .BASE(BASE), .FLAG(FLAG)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .slot_sel (slot_sel),
    .flag_sel (flag_sel)
  );

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    cmp_slot #(.DW(DW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bus_wr && slot_sel[i]),
      .load_val (bus_wdata),
      .clr      (bus_wr && flag_sel && bus_wdata[i]),
      .count    (count_in),
      .value    (values[i]),
      .flag     (flags[i])
    );
  end

  cmp_rd_path #(.N_SLOT(N_SLOT), .DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .slot_sel (slot_sel),
    .flag_sel (flag_sel),
    .values   (values),
    .flags    (flags),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assign irq_o = |flags;
endmodule

// File: tb/cmp_event_gen_test.sv
module cmp_event_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] count_in = '0;
  logic        irq_o;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  cmp_event_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .count_in(count_in), .irq_o(irq_o)
  );

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic probe(input logic [7:0] a, input logic [31:0] d,
                       input logic q, input string tag);
    exp_t e;
    e.data = d; e.irq = q; e.tag = tag;
    exp_q.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      exp_t e;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected response: actual %h, expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.data || irq_o !== e.irq) begin
          n_bad++;
          $display("FAIL %s: actual data %h irq %b, expected data %h irq %b",
                   e.tag, bus_rdata, irq_o, e.data, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state, count 0 equals reset values but nothing armed
    probe(8'h80, 32'h0, 1'b0, "R1");
    probe(8'h60, 32'h0, 1'b0, "R1");

    // R2: store and read back
    count_in = 32'd5;
    bus_write(8'h60, 32'd100);
    probe(8'h60, 32'd100, 1'b0, "R2");
    bus_write(8'h74, 32'hCAFE_0005);
    probe(8'h74, 32'hCAFE_0005, 1'b0, "R2");

    // R3 R6: a match raises flag 0 and the interrupt
    count_in = 32'd100; idle(1); count_in = 32'd7;
    probe(8'h80, 32'h1, 1'b1, "R3_R6");

    // R5: zero bits keep flags, one bits clear
    bus_write(8'h80, 32'h0);
    probe(8'h80, 32'h1, 1'b1, "R5");
    bus_write(8'h80, 32'h1);
    probe(8'h80, 32'h0, 1'b0, "R5");

    // R4: no second event from a fired slot
    count_in = 32'd100; idle(2); count_in = 32'd7;
    probe(8'h80, 32'h0, 1'b0, "R4");

    // R7: equality during the write cycle is ignored
    count_in = 32'd200;
    bus_write(8'h64, 32'd200);
    count_in = 32'd201;
    probe(8'h80, 32'h0, 1'b0, "R7");
    count_in = 32'd200; idle(1); count_in = 32'd201;
    probe(8'h80, 32'h2, 1'b1, "R7");
    bus_write(8'h80, 32'h2);

    // R9: match and clear in the same cycle keeps the flag
    bus_write(8'h68, 32'd300);
    count_in = 32'd300;
    bus_write(8'h80, 32'h4);
    count_in = 32'd301;
    probe(8'h80, 32'h4, 1'b1, "R9");
    bus_write(8'h80, 32'h4);
    probe(8'h80, 32'h0, 1'b0, "R9");

    // R3: two slots match together
    bus_write(8'h6C, 32'd500);
    bus_write(8'h70, 32'd500);
    count_in = 32'd500; idle(1); count_in = 32'd501;
    probe(8'h80, 32'h18, 1'b1, "R3");
    bus_write(8'h80, 32'hFF);
    probe(8'h80, 32'h0, 1'b0, "R3");

    // R8: target past the wrap
    count_in = 32'hFFFF_FFF0;
    bus_write(8'h7C, 32'hFFFF_FFF0 + 32'h20);
    for (int k = 1; k < 16; k++) begin
      count_in = 32'hFFFF_FFF0 + 32'(k); idle(1);
    end
    probe(8'h80, 32'h0, 1'b0, "R8");
    for (int k = 0; k < 32; k++) begin
      count_in = 32'(k); idle(1);
    end
    probe(8'h80, 32'h80, 1'b1, "R8");
    bus_write(8'h80, 32'h80);
    probe(8'h7C, 32'h10, 1'b0, "R8");

    // R10: unmapped and misaligned writes change nothing
    bus_write(8'h5C, 32'd77);
    bus_write(8'h84, 32'hFF);
    bus_write(8'h62, 32'd77);
    probe(8'h60, 32'd100, 1'b0, "R10");
    probe(8'h64, 32'd200, 1'b0, "R10");
    probe(8'h5C, 32'h0, 1'b0, "R10");
    count_in = 32'd77; idle(1); count_in = 32'd100; idle(1); count_in = 32'd7;
    probe(8'h80, 32'h0, 1'b0, "R10");

    idle(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule